// File: doc/BRIEF.md
# Register Access Error Classifier

This block sits behind the transaction decoder of a serial-bus register slave. When a register access has completed, the front end presents a single descriptor for it: direction, target address, the number of data bytes moved, whether a packet check byte was attached, the check byte that was received, and the check byte the front end computed locally over the address, command and data bytes. The check is a CRC-8 with polynomial x^8+x^2+x+1 and initial value 0x00.

The classifier looks up the target address in a constant attribute table. The table gives the width of each register and its access rights. The classifier then sorts every illegal access into exactly one of four error classes and emits a single-cycle event pulse for that class. The status register logic collects these pulses into latched flags.

The classifier also outputs a gated write enable. The register file uses it so that a flawed transaction never modifies a register.

Top module: `reg_access_err_classifier`

## Requirements
- R1: While rst_ni is low, and after its release until the first transaction, every output is 0.
- R2: A transaction to an address with no register raises ev_bad_cmd_o in the cycle after txn_valid_i is sampled. Defined addresses are 0x00-0x37. Any address from 0x38 to 0xFF has no register.
- R3: A transaction whose txn_len_i differs from the register width raises ev_bad_data_o. The width is 1 byte for byte registers and 2 bytes for word registers, and the rule applies to reads and to writes.
- R4: When pec_en_i is 1 and pec_rx_i differs from pec_calc_i, ev_pec_o is raised. When pec_en_i is 0, both check bytes are ignored.
- R5: Reading a write-only register or writing a read-only register raises ev_comm_o, provided none of the classes in R2-R4 applies.
- R6: The classes are ranked, highest first: check-byte failure, undefined address, size mismatch, access-right violation. At most one output among the four events and wr_en_o is high in any cycle.
- R7: wr_en_o pulses in the cycle after a write that raises no event. It stays low after a read and after any write that raises an event.
- R8: Every output is a one-cycle pulse. An output can be high only in the cycle directly after a cycle in which txn_valid_i was sampled high. Transactions in back-to-back cycles each produce their own result.
- R9: The attribute map, by address range:
  - 0x00-0x0F: byte wide, read/write.
  - 0x10-0x1F: word wide, read/write.
  - 0x20-0x27: word wide, read-only.
  - 0x28-0x2F: byte wide, read-only.
  - 0x30-0x33: byte wide, write-only.
  - 0x34-0x37: word wide, write-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | Descriptor valid for one cycle per completed transaction |
| txn_read_i | input | 1 | 1 = read, 0 = write |
| txn_addr_i | input | ADDR_W (8) | Target register address |
| txn_len_i | input | LEN_W (3) | Number of data bytes transferred |
| pec_en_i | input | 1 | A check byte was attached to the transaction |
| pec_rx_i | input | 8 | Check byte received on the bus |
| pec_calc_i | input | 8 | Check byte computed by the front end |
| ev_pec_o | output | 1 | Check-byte failure event |
| ev_bad_cmd_o | output | 1 | Undefined-address event |
| ev_bad_data_o | output | 1 | Size-mismatch event |
| ev_comm_o | output | 1 | Other communication error event |
| wr_en_o | output | 1 | Write enable for the register file, clean writes only |

## Verification
The hardest cases are transactions that break several rules at once. Only the ranking decides which single event appears for them. Examples are a bad check byte on an undefined address, or a wrongly sized write to a read-only register. The vector table includes each such overlap. It also includes cases where the check bytes differ but pec_en_i is low, to confirm that they are ignored. Transactions are also issued in consecutive cycles, and a reset is applied while an event is pending, to exercise the pulse boundaries.

// File: rtl/reg_err_pkg.sv
package reg_err_pkg;

  typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_BYTE = 2'd1, SZ_WORD = 2'd2} reg_size_e;
  typedef enum logic [1:0] {ACC_RW = 2'd0, ACC_RO = 2'd1, ACC_WO = 2'd2} reg_acc_e;

  typedef struct packed {
    reg_size_e size;
    reg_acc_e  acc;
  } reg_attr_t;

  // event vector order: {pec, bad_cmd, bad_data, comm}
  localparam int unsigned EV_N = 4;

  function automatic reg_attr_t attr_of(input int unsigned a);
    reg_attr_t r;
    r.size = SZ_NONE;
    r.acc  = ACC_RW;
    if (a <= 32'h0F)      begin r.size = SZ_BYTE; r.acc = ACC_RW; end
    else if (a <= 32'h1F) begin r.size = SZ_WORD; r.acc = ACC_RW; end
    else if (a <= 32'h27) begin r.size = SZ_WORD; r.acc = ACC_RO; end
    else if (a <= 32'h2F) begin r.size = SZ_BYTE; r.acc = ACC_RO; end
    else if (a <= 32'h33) begin r.size = SZ_BYTE; r.acc = ACC_WO; end
    else if (a <= 32'h37) begin r.size = SZ_WORD; r.acc = ACC_WO; end
    return r;
  endfunction

  function automatic int unsigned size_bytes(input reg_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/reg_attr_rom.sv
module reg_attr_rom
  import reg_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_attr_t         attr_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  reg_attr_t table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign table_q[i] = attr_of(i);
  end

  assign attr_o = table_q[addr_i];
endmodule

// File: rtl/reg_err_decide.sv
module reg_err_decide
  import reg_err_pkg::*;
#(
  parameter int unsigned LEN_W = 3,
  parameter int unsigned PEC_W = 8
) (
  input  logic             valid_i,
  input  logic             read_i,
  input  reg_attr_t        attr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pec_en_i,
  input  logic [PEC_W-1:0] pec_rx_i,
  input  logic [PEC_W-1:0] pec_calc_i,
  output logic [EV_N-1:0]  ev_o,
  output logic             wr_ok_o
);
  logic pec_bad, undef, size_bad, acc_bad;

  assign pec_bad  = pec_en_i && (pec_rx_i != pec_calc_i);
  assign undef    = (attr_i.size == SZ_NONE);
  assign size_bad = (32'(len_i) != size_bytes(attr_i.size));
  assign acc_bad  = (read_i && attr_i.acc == ACC_WO) || (!read_i && attr_i.acc == ACC_RO);

  always_comb begin
    ev_o    = '0;
    wr_ok_o = 1'b0;
    if (valid_i) begin
      if (pec_bad)       ev_o[3] = 1'b1;
      else if (undef)    ev_o[2] = 1'b1;
      else if (size_bad) ev_o[1] = 1'b1;
      else if (acc_bad)  ev_o[0] = 1'b1;
      else               wr_ok_o = !read_i;
    end
  end
endmodule

// File: rtl/reg_access_err_classifier.sv
module reg_access_err_classifier
  import reg_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned PEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_valid_i,
  input  logic              txn_read_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [LEN_W-1:0]  txn_len_i,
  input  logic              pec_en_i,
  input  logic [PEC_W-1:0]  pec_rx_i,
  input  logic [PEC_W-1:0]  pec_calc_i,
  output logic              ev_pec_o,
  output logic              ev_bad_cmd_o,
  output logic              ev_bad_data_o,
  output logic              ev_comm_o,
  output logic              wr_en_o
);
  reg_attr_t       attr;
  logic [EV_N-1:0] ev_d, ev_q;
  logic            wr_d, wr_q;

  reg_attr_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr_i (txn_addr_i),
    .attr_o (attr)
  );

  reg_err_decide #(.LEN_W(LEN_W), .PEC_W(PEC_W)) u_decide (
    .valid_i    (txn_valid_i),
    .read_i     (txn_read_i),
    .attr_i     (attr),
    .len_i      (txn_len_i),
    .pec_en_i   (pec_en_i),
    .pec_rx_i   (pec_rx_i),
    .pec_calc_i (pec_calc_i),
    .ev_o       (ev_d),
    .wr_ok_o    (wr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
      wr_q <= 1'b0;
    end else begin
      ev_q <= ev_d;
      wr_q <= wr_d;
    end
  end

  assign {ev_pec_o, ev_bad_cmd_o, ev_bad_data_o, ev_comm_o} = ev_q;
  assign wr_en_o = wr_q;
endmodule

// File: rtl/reg_access_err_classifier_chk.sv
module reg_access_err_classifier_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              txn_valid_i,
  input logic              txn_read_i,
  input logic [ADDR_W-1:0] txn_addr_i,
  input logic              pec_en_i,
  input logic [PEC_W-1:0]  pec_rx_i,
  input logic [PEC_W-1:0]  pec_calc_i,
  input logic              ev_pec_o,
  input logic              ev_bad_cmd_o,
  input logic              ev_bad_data_o,
  input logic              ev_comm_o,
  input logic              wr_en_o
);
  logic [4:0] outs;
  assign outs = {ev_pec_o, ev_bad_cmd_o, ev_bad_data_o, ev_comm_o, wr_en_o};

  a_r6_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(outs));

  a_r8_only_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outs != '0) |-> $past(txn_valid_i));

  a_r7_no_wr_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !$past(txn_read_i));

  a_r4_pec_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && pec_en_i && pec_rx_i != pec_calc_i) |=> ev_pec_o);

  a_r2_undefined_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_addr_i > 8'h37 && !(pec_en_i && pec_rx_i != pec_calc_i))
      |=> ev_bad_cmd_o);
endmodule

bind reg_access_err_classifier reg_access_err_classifier_chk #(
  .ADDR_W(ADDR_W), .PEC_W(PEC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .txn_valid_i   (txn_valid_i),
  .txn_read_i    (txn_read_i),
  .txn_addr_i    (txn_addr_i),
  .pec_en_i      (pec_en_i),
  .pec_rx_i      (pec_rx_i),
  .pec_calc_i    (pec_calc_i),
  .ev_pec_o      (ev_pec_o),
  .ev_bad_cmd_o  (ev_bad_cmd_o),
  .ev_bad_data_o (ev_bad_data_o),
  .ev_comm_o     (ev_comm_o),
  .wr_en_o       (wr_en_o)
);

// File: tb/reg_access_err_classifier_bench.sv
module reg_access_err_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // {read, addr[8], len[3], pec_en, rx[8], calc[8], exp{pec,cmd,data,comm,wr}} = 34 bits
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 8'h05, 3'd1, 1'b0, 8'h00, 8'h00, 5'b00001}, // R7 clean byte write
    {1'b0, 8'h12, 3'd2, 1'b1, 8'h5A, 8'h5A, 5'b00001}, // R7 word write, good check
    {1'b1, 8'h22, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00000}, // R7 clean read, no wr
    {1'b0, 8'h40, 3'd1, 1'b0, 8'h00, 8'h00, 5'b01000}, // R2 undefined write
    {1'b1, 8'hFF, 3'd1, 1'b0, 8'h00, 8'h00, 5'b01000}, // R2 undefined read
    {1'b0, 8'h05, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00100}, // R3 word to byte reg
    {1'b1, 8'h24, 3'd1, 1'b0, 8'h00, 8'h00, 5'b00100}, // R3 short read of word reg
    {1'b1, 8'h31, 3'd1, 1'b0, 8'h00, 8'h00, 5'b00010}, // R5 read write-only
    {1'b0, 8'h20, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00010}, // R5 write read-only
    {1'b0, 8'h05, 3'd1, 1'b1, 8'h11, 8'h12, 5'b10000}, // R4 bad check byte
    {1'b0, 8'h40, 3'd2, 1'b1, 8'h00, 8'hFF, 5'b10000}, // R6 pec over cmd
    {1'b0, 8'h12, 3'd1, 1'b1, 8'hA0, 8'hA1, 5'b10000}, // R6 pec over data
    {1'b0, 8'h34, 3'd1, 1'b0, 8'h33, 8'h44, 5'b00100}, // R4 ignored check, R3 size
    {1'b0, 8'h2A, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00100}, // R6 data over comm
    {1'b0, 8'h36, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00001}, // R9 word write-only ok
    {1'b1, 8'h0F, 3'd1, 1'b0, 8'h00, 8'h00, 5'b00000}, // R9 edge of byte rw
    {1'b0, 8'h37, 3'd2, 1'b0, 8'h01, 8'h02, 5'b00001}, // R4 ignored, R9 last defined
    {1'b1, 8'h38, 3'd1, 1'b0, 8'h00, 8'h00, 5'b01000}, // R2 first undefined
    {1'b0, 8'h1F, 3'd2, 1'b0, 8'h00, 8'h00, 5'b00001}, // R9 edge of word rw
    {1'b1, 8'h28, 3'd1, 1'b1, 8'h7E, 8'h7E, 5'b00000}  // R9 byte ro read, good check
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       txn_valid_i = 1'b0, txn_read_i = 1'b0, pec_en_i = 1'b0;
  logic [7:0] txn_addr_i = '0, pec_rx_i = '0, pec_calc_i = '0;
  logic [2:0] txn_len_i = '0;
  logic       ev_pec_o, ev_bad_cmd_o, ev_bad_data_o, ev_comm_o, wr_en_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  reg_access_err_classifier u_reg_access_err_classifier (
    .clk_i, .rst_ni, .txn_valid_i, .txn_read_i, .txn_addr_i, .txn_len_i,
    .pec_en_i, .pec_rx_i, .pec_calc_i,
    .ev_pec_o, .ev_bad_cmd_o, .ev_bad_data_o, .ev_comm_o, .wr_en_o
  );

  function automatic logic [4:0] outs();
    return {ev_pec_o, ev_bad_cmd_o, ev_bad_data_o, ev_comm_o, wr_en_o};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic drive(input logic [33:0] v);
    txn_valid_i = 1'b1;
    txn_read_i  = v[33];
    txn_addr_i  = v[32:25];
    txn_len_i   = v[24:22];
    pec_en_i    = v[21];
    pec_rx_i    = v[20:13];
    pec_calc_i  = v[12:5];
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2);
    check("R1 in reset", 5'b00000);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 5'b00000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i) drive(VEC[i]);
      @(negedge clk_i) txn_valid_i = 1'b0;
      check($sformatf("R6 vector %0d", i), VEC[i][4:0]);
      @(negedge clk_i);
      check($sformatf("R8 idle after vector %0d", i), 5'b00000);
    end

    // R8 back-to-back transactions
    @(negedge clk_i) drive(VEC[3]);
    @(negedge clk_i) drive(VEC[0]);
    check("R8 first of pair", 5'b01000);
    @(negedge clk_i) txn_valid_i = 1'b0;
    check("R8 second of pair", 5'b00001);

    // R8 descriptor fields without valid have no effect
    @(negedge clk_i) begin drive(VEC[9]); txn_valid_i = 1'b0; end
    @(negedge clk_i);
    check("R8 no valid", 5'b00000);

    // R1 reset with an event pending
    @(negedge clk_i) drive(VEC[5]);
    @(negedge clk_i) txn_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1 check("R1 async clear", 5'b00000);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 stays clear", 5'b00000);

    finish_run();
  end
endmodule